// File: doc/BRIEF.md
# Streaming Bit-Matrix Transposer

The block takes a stream of N-bit integers, treats every group of N consecutive integers as a square N×N bit matrix, and returns the transpose of that matrix as a stream of N-bit integers. Both sides carry 128-bit beats. Each beat packs K = 128/N integers, so a beat holds four integers when N is 32 and two when N is 64.

Every column of the matrix has its own accumulator. On each accepted input beat, every accumulator shifts by K bit positions at once, so a full matrix is captured in N/K beats. Two matrix buffers take turns. While one buffer fills, the other drains. Loading and draining therefore overlap, and a steady stream passes through with no gaps.

Input and output use valid/ready handshakes. A flag on the output marks the last beat of each transposed matrix.

Top module: `bmt_transposer`

## Requirements
- R1: For each group of N consecutive input integers (rows 0..N-1), output integer j of the matching output matrix has bit i equal to bit j of input integer i.
- R2: A beat carries K = 128/N integers, with lane l at bits [l*N +: N]. Lane 0 is the earliest integer in stream order. Output beats use the same lane order.
- R3: The output rows of a matrix leave in order 0 to N-1, in N/K beats. Matrices leave in the order they arrived.
- R4: `out_last` is high on the final beat of each transposed matrix and low on all other valid beats.
- R5: Once `out_valid` is high, it stays high and `out_data`/`out_last` stay unchanged until a cycle in which `out_ready` is high.
- R6: `in_ready` is low only when two complete matrices are waiting or draining. No accepted beat is lost under output backpressure.
- R7: While `rst_n` is low at a clock edge, both buffers are emptied and all counters are cleared. After reset, `in_ready` is 1 and `out_valid` is 0. Any partly loaded matrix is discarded and never shows up at the output.
- R8: With `in_valid` and `out_ready` held high, `in_ready` stays high. The next matrix loads while the previous one drains.
- R9: `out_valid` is never high unless at least one complete matrix has been accepted and not yet fully emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | BEAT_W (128) | K packed input integers, lane 0 earliest |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Sink takes the output beat |
| out_data | output | BEAT_W (128) | K packed transposed rows, lane 0 lowest row |
| out_last | output | 1 | Final beat of a transposed matrix |

## Verification
The bench builds two copies of the block. One uses 32-bit integers (four lanes, 8 beats per matrix). The other uses 64-bit integers (two lanes, 32 beats per matrix). Running both exercises the 4-bit and the 2-bit accumulator shift, two different read-mux widths, and two counter lengths.

Under both settings, the bench checks the following against a bit-level reference model:
- back-to-back streaming;
- stalls that fill both buffers;
- random valid/ready patterns;
- a reset that arrives in the middle of a matrix.

// File: rtl/bmt_pkg.sv
// Package: shared helpers for the bit-matrix transposer.
// Assumes callers pass positive counts.
package bmt_pkg;

    // Width of a counter that must hold the values 0..n-1 (at least one bit).
    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Number of matrix buffers used for ping-pong operation.
    localparam int NUM_BANKS = 2;

endpackage

// File: rtl/bmt_bank.sv
// Module: one matrix buffer, built from N column accumulators.
// On load_en, column j shifts right by K bits and takes in bit j of every
// lane of the beat. Lane 0 lands lowest, so after N/K loads bit i of
// column j holds bit j of row i. Read side: beat rd_idx returns columns
// rd_idx*K .. rd_idx*K+K-1 packed lane by lane.
// Assumes K < ELEM_W and ELEM_W divisible by K. Data is not reset, because
// the control logic tracks whether the contents are valid.
module bmt_bank
    import bmt_pkg::*;
#(
    parameter int BEAT_W = 128,
    parameter int ELEM_W = 32,
    localparam int K     = BEAT_W / ELEM_W,
    localparam int BEATS = ELEM_W / K,
    localparam int CW    = cnt_w(BEATS)
) (
    input  logic              clk,
    input  logic              load_en,
    input  logic [BEAT_W-1:0] in_beat,
    input  logic [CW-1:0]     rd_idx,
    output logic [BEAT_W-1:0] rd_beat
);

    logic [ELEM_W-1:0] col_w [ELEM_W];

    for (genvar j = 0; j < ELEM_W; j++) begin : g_col
        logic [K-1:0]      slice;
        logic [ELEM_W-1:0] acc_q;

        for (genvar l = 0; l < K; l++) begin : g_lane
            // Collect bit j of lane l; lane 0 is the earliest row.
            assign slice[l] = in_beat[l*ELEM_W + j];
        end

        // Shift the column by K bits, inserting the new rows at the top.
        always_ff @(posedge clk) begin
            if (load_en) begin
                acc_q <= {slice, acc_q[ELEM_W-1:K]};
            end
        end

        assign col_w[j] = acc_q;
    end

    // Pack K consecutive columns into one output beat.
    always_comb begin
        for (int l = 0; l < K; l++) begin
            rd_beat[l*ELEM_W +: ELEM_W] = col_w[int'(rd_idx) * K + l];
        end
    end

endmodule

// File: rtl/bmt_ctrl.sv
// Module: ping-pong control for the two matrix buffers.
// Each bank has a full flag. The writer fills bank wr_sel until it holds
// BEATS beats, marks it full and moves to the other bank. The reader
// drains bank rd_sel while it is full, clears the flag after the last
// beat and moves on. The input stalls only if the writer's bank is still
// full.
// Assumes a synchronous active-low reset.
module bmt_ctrl
    import bmt_pkg::*;
#(
    parameter int BEATS = 8,
    localparam int CW   = cnt_w(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic          out_last,
    output logic          wr_fire,
    output logic          wr_sel,
    output logic          rd_sel,
    output logic [CW-1:0] rd_idx
);

    localparam logic [CW-1:0] LAST_IDX = CW'(BEATS - 1);

    logic [NUM_BANKS-1:0] full_q, full_d;
    logic                 wr_sel_q, rd_sel_q;
    logic [CW-1:0]        wr_cnt_q, rd_cnt_q;
    logic                 rd_fire, wr_done, rd_done;

    assign in_ready  = !full_q[wr_sel_q];
    assign wr_fire   = in_valid && in_ready;
    assign out_valid = full_q[rd_sel_q];
    assign rd_fire   = out_valid && out_ready;
    assign wr_done   = wr_fire && (wr_cnt_q == LAST_IDX);
    assign rd_done   = rd_fire && (rd_cnt_q == LAST_IDX);
    assign out_last  = out_valid && (rd_cnt_q == LAST_IDX);
    assign wr_sel    = wr_sel_q;
    assign rd_sel    = rd_sel_q;
    assign rd_idx    = rd_cnt_q;

    // Next full flags: set on the writer's last beat, clear on the reader's.
    always_comb begin
        full_d = full_q;
        if (wr_done) full_d[wr_sel_q] = 1'b1;
        if (rd_done) full_d[rd_sel_q] = 1'b0;
    end

    // Bank occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= '0;
        else        full_q <= full_d;
    end

    // Write beat counter and write bank pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt_q <= '0;
            wr_sel_q <= 1'b0;
        end else if (wr_fire) begin
            wr_cnt_q <= wr_done ? '0 : wr_cnt_q + 1'b1;
            if (wr_done) wr_sel_q <= !wr_sel_q;
        end
    end

    // Read beat counter and read bank pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt_q <= '0;
            rd_sel_q <= 1'b0;
        end else if (rd_fire) begin
            rd_cnt_q <= rd_done ? '0 : rd_cnt_q + 1'b1;
            if (rd_done) rd_sel_q <= !rd_sel_q;
        end
    end

endmodule

// File: rtl/bmt_transposer.sv
// Module: streaming N x N bit-matrix transposer with packed 128-bit beats.
// Every group of ELEM_W input integers forms a matrix. The transposed rows
// leave K per beat in row order, with out_last on the last beat of each
// matrix. Two buffers let one matrix load while the previous one drains.
// Assumes BEAT_W is a multiple of ELEM_W and K < ELEM_W.
module bmt_transposer
    import bmt_pkg::*;
#(
    parameter int BEAT_W = 128,
    parameter int ELEM_W = 32,
    localparam int K     = BEAT_W / ELEM_W,
    localparam int BEATS = ELEM_W / K,
    localparam int CW    = cnt_w(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BEAT_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_last
);

    logic              wr_fire, wr_sel, rd_sel;
    logic [CW-1:0]     rd_idx;
    logic [BEAT_W-1:0] bank_rd [NUM_BANKS];

    bmt_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .wr_fire   (wr_fire),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel),
        .rd_idx    (rd_idx)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic load_en;
        // Load only the bank the writer currently points at.
        assign load_en = wr_fire && (wr_sel == 1'(b));

        bmt_bank #(.BEAT_W(BEAT_W), .ELEM_W(ELEM_W)) u_bank (
            .clk     (clk),
            .load_en (load_en),
            .in_beat (in_data),
            .rd_idx  (rd_idx),
            .rd_beat (bank_rd[b])
        );
    end

    // Output comes from the bank being drained.
    assign out_data = rd_sel ? bank_rd[1] : bank_rd[0];

endmodule

// File: rtl/bmt_checker.sv
// Module: protocol checker for bmt_transposer, attached through bind.
// It keeps its own counts of input and output beats and matrices, and
// relates the handshake ports to them.
module bmt_checker #(
    parameter int BEAT_W = 128,
    parameter int ELEM_W = 32,
    localparam int K     = BEAT_W / ELEM_W,
    localparam int BEATS = ELEM_W / K,
    localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BEAT_W-1:0] out_data,
    input logic              out_last
);

    logic [CW-1:0] in_cnt_q, out_cnt_q;
    logic [2:0]    in_mat_q, out_mat_q;
    logic [2:0]    pending;

    assign pending = in_mat_q - out_mat_q;

    // Independent beat and matrix counters on both sides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cnt_q  <= '0;
            out_cnt_q <= '0;
            in_mat_q  <= '0;
            out_mat_q <= '0;
        end else begin
            if (in_valid && in_ready) begin
                if (in_cnt_q == CW'(BEATS - 1)) begin
                    in_cnt_q <= '0;
                    in_mat_q <= in_mat_q + 3'd1;
                end else begin
                    in_cnt_q <= in_cnt_q + 1'b1;
                end
            end
            if (out_valid && out_ready) begin
                if (out_cnt_q == CW'(BEATS - 1)) begin
                    out_cnt_q <= '0;
                    out_mat_q <= out_mat_q + 3'd1;
                end else begin
                    out_cnt_q <= out_cnt_q + 1'b1;
                end
            end
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);                          // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_last))); // R5
    AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (out_cnt_q == CW'(BEATS - 1))));        // R4
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);                                           // R4
    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (pending == 3'd2));                                  // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= 3'd2);                                                  // R6
    AST_VALID_HAS_MATRIX: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pending != 3'd0));                                  // R9
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid));                              // R7

endmodule

bind bmt_transposer bmt_checker #(.BEAT_W(BEAT_W), .ELEM_W(ELEM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/bmt_transposer_tb_top.sv
`timescale 1ns/1ps

// One test unit: drives one transposer instance and checks it against a
// bit-level reference model.
module bmt_tb_unit #(
    parameter int ELEM_W = 32,
    parameter int SEED   = 1
) (
    input  logic clk,
    output logic done,
    output int   n_chk,
    output int   n_fail
);
    localparam int BEAT_W = 128;
    localparam int K      = BEAT_W / ELEM_W;
    localparam int BEATS  = ELEM_W / K;

    logic              rst_n, in_valid, in_ready, out_valid, out_ready, out_last;
    logic [BEAT_W-1:0] in_data, out_data;

    bmt_transposer #(.BEAT_W(BEAT_W), .ELEM_W(ELEM_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    logic [ELEM_W-1:0] elems [$];
    logic [BEAT_W:0]   exp_q [$];
    int                in_mats, out_mats;
    bit                prev_stall, chk_r8;
    logic [BEAT_W:0]   prev_out;

    task automatic check(input bit ok, input string req,
                         input logic [BEAT_W:0] act, input logic [BEAT_W:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (N=%0d) actual=%h expected=%h", req, ELEM_W, act, exp);
        end
    endtask

    function automatic logic [BEAT_W-1:0] rnd_beat();
        logic [BEAT_W-1:0] r;
        for (int w = 0; w < BEAT_W / 32; w++) r[w*32 +: 32] = $urandom;
        return r;
    endfunction

    // Reference model: unpack the lanes and transpose each complete matrix.
    function automatic void model_in(input logic [BEAT_W-1:0] d);
        logic [ELEM_W-1:0] t [ELEM_W];
        logic [BEAT_W-1:0] b;
        for (int l = 0; l < K; l++) elems.push_back(d[l*ELEM_W +: ELEM_W]);
        if (elems.size() == ELEM_W) begin
            for (int j = 0; j < ELEM_W; j++)
                for (int i = 0; i < ELEM_W; i++) t[j][i] = elems[i][j];
            for (int bi = 0; bi < BEATS; bi++) begin
                for (int l = 0; l < K; l++) b[l*ELEM_W +: ELEM_W] = t[bi*K + l];
                exp_q.push_back({(bi == BEATS - 1), b});
            end
            elems.delete();
            in_mats++;
        end
    endfunction

    // One cycle: drive at the falling edge, check 1 ns later, then advance.
    task automatic step(input bit iv, input logic [BEAT_W-1:0] d, input bit ordy);
        logic [BEAT_W:0] e;
        in_valid  = iv;
        in_data   = d;
        out_ready = ordy;
        #1;
        if (prev_stall)
            check(out_valid && {out_last, out_data} == prev_out, "R5",
                  {out_last, out_data}, prev_out);
        if (!in_ready)
            check(in_mats - out_mats == 2, "R6", BEAT_W'(in_mats - out_mats), 2);
        if (out_valid)
            check(in_mats - out_mats >= 1, "R9", BEAT_W'(in_mats - out_mats), 1);
        if (chk_r8)
            check(in_ready, "R8", {128'd0, in_ready}, 1);
        if (out_valid && ordy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected beat", {out_last, out_data}, 0);
            end else begin
                e = exp_q.pop_front();
                // R1 transpose, R2 lane order, R3 row order, R4 last flag
                check({out_last, out_data} == e, "R1/R2/R3/R4", {out_last, out_data}, e);
                if (e[BEAT_W]) out_mats++;
            end
        end
        if (iv && in_ready) model_in(d);
        prev_stall = out_valid && !ordy;
        prev_out   = {out_last, out_data};
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready && !out_valid, "R7 reset state",
              {127'd0, in_ready, out_valid}, {127'd0, 2'b10});
        elems.delete(); exp_q.delete();
        in_mats = 0; out_mats = 0; prev_stall = 0;
        @(negedge clk);
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 4 * BEATS + 8) begin
            step(1'b0, '0, 1'b1);
            guard++;
        end
        check(exp_q.size() == 0, "R3 all rows emitted", BEAT_W'(exp_q.size()), 0);
    endtask

    initial begin
        logic [BEAT_W-1:0] bt;
        done = 0; n_chk = 0; n_fail = 0; chk_r8 = 0;
        rst_n = 0; in_valid = 0; out_ready = 0; in_data = '0;
        void'($urandom(SEED));
        @(negedge clk);
        do_reset();

        // Directed matrix: row r = r ^ (1 << r), which is not symmetric (R1, R2).
        for (int b = 0; b < BEATS; b++) begin
            for (int l = 0; l < K; l++)
                bt[l*ELEM_W +: ELEM_W] = ELEM_W'(b*K + l) ^ (ELEM_W'(1) << (b*K + l));
            step(1'b1, bt, 1'b1);
        end
        drain();

        // Backpressure: both buffers fill, then the input must stall (R6).
        repeat (3 * BEATS) step(1'b1, rnd_beat(), 1'b0);
        in_valid = 1'b0;
        #1;
        check(!in_ready && out_valid, "R6 stall when both full",
              {127'd0, in_ready, out_valid}, {127'd0, 2'b01});
        @(negedge clk);
        drain();

        // Back-to-back streaming with no stall (R8).
        chk_r8 = 1;
        repeat (4 * BEATS) step(1'b1, rnd_beat(), 1'b1);
        chk_r8 = 0;
        drain();

        // Random handshakes.
        repeat (800) step(($urandom % 4) != 0, rnd_beat(), ($urandom % 3) != 0);
        while (elems.size() != 0) step(1'b1, rnd_beat(), 1'b1);
        drain();

        // Partial matrix: no output (R9), then reset discards it (R7).
        repeat (3) step(1'b1, rnd_beat(), 1'b0);
        in_valid = 1'b0;
        #1;
        check(!out_valid, "R9 partial matrix", {128'd0, out_valid}, 0);
        @(negedge clk);
        do_reset();
        repeat (BEATS) step(1'b1, rnd_beat(), 1'b1);
        drain();
        check(elems.size() == 0 && out_mats == 1, "R7 only post-reset matrix",
              BEAT_W'(out_mats), 1);

        done = 1;
    end
endmodule

module bmt_transposer_tb_top;
    logic clk = 1'b0;
    logic d32, d64;
    int   c32, f32, c64, f64;

    always #2.5 clk = ~clk;

    bmt_tb_unit #(.ELEM_W(32), .SEED(1234)) u_w32 (.clk(clk), .done(d32), .n_chk(c32), .n_fail(f32));
    bmt_tb_unit #(.ELEM_W(64), .SEED(5678)) u_w64 (.clk(clk), .done(d64), .n_chk(c64), .n_fail(f64));

    initial begin
        int  total, failed;
        bit  timed_out = 1;
        repeat (100000) begin
            @(posedge clk);
            if (d32 === 1'b1 && d64 === 1'b1) begin
                timed_out = 0;
                break;
            end
        end
        total  = c32 + c64;
        failed = f32 + f64;
        if (timed_out) begin
            total++;
            failed++;
            $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
        end
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule